// File: doc/BRIEF.md
# DLL Delay-Setting Control Loop

This block is the digital half of a delay-locked loop. A reference clock runs through a chain of at most 16 delay elements, and the total delay of that chain is set by a six-bit control word. A phase comparator looks at the output of the last element against the reference clock. It reduces the comparison to a single direction bit: add delay or remove delay. That bit is the only input that can move the setting.

The block holds the setting in a saturating up/down counter whose state is kept in Gray code. Each step therefore flips exactly one bit of the word that the delay chain and the DQS delay consumers see. A divider lets the counter step only once every `UPD_DIV` reference cycles, which gives the chain time to settle before the next comparison counts. A binary copy of the setting is decoded from the Gray state. A lock detector watches the pattern of direction bits. It declares lock once the direction has alternated for enough consecutive updates, and it drops lock when the direction stays the same for too long.

Top module: `dll_delay_ctrl`

## Requirements
- R1: Driving `rst_n` low forces `dly_gray` to 6'b110000 (binary 32 in Gray code), `dly_bin` to 32 and `dll_locked` to 0 at once. The release of `rst_n` passes through a two-stage synchronizer.
- R2: Updates happen once every `UPD_DIV` rising edges. The first update is on the (`UPD_DIV`+2)-th rising edge after `rst_n` rises. On every other edge the outputs hold and `phase_up` is ignored.
- R3: At an update, `phase_up`=1 raises the binary setting by one (more delay) and `phase_up`=0 lowers it by one (less delay).
- R4: The setting saturates. An up-update at 63 leaves it at 63, a down-update at 0 leaves it at 0, and it never wraps.
- R5: `dly_gray` equals bin ^ (bin >> 1) of the setting, and no more than one bit of it changes from one clock to the next.
- R6: `dly_bin` is the binary value decoded from `dly_gray`, valid in the same cycle.
- R7: An update whose direction differs from the previous update's direction counts as an alternation. The first update after reset is not an alternation. `dll_locked` rises at the update on which the count of consecutive alternations reaches `LOCK_ALT`.
- R8: `dll_locked` falls at the update on which the count of consecutive same-direction updates exceeds `UNLOCK_RUN`. The count includes the first update of the run.
- R9: `dll_locked` changes only on update edges and otherwise keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_up | input | 1 | Phase direction: 1 = add delay, 0 = remove delay |
| dly_gray | output | 6 | Gray-coded delay setting to the chain and DQS consumers |
| dly_bin | output | 6 | Binary copy of the delay setting |
| dll_locked | output | 1 | Lock status |

## Verification
Reset acts on the outputs at once, with no clock needed. Its release takes two synchronizer edges, so the first update lands on rising edge `UPD_DIV`+2 and later updates follow every `UPD_DIV` edges. The setting, its binary copy and the lock flag are all registered, or decoded, at that same update edge. The bench therefore sets `phase_up` on the falling edge before each update edge and checks all three outputs on the falling edge just after it. On each falling edge in between, it flips `phase_up` and confirms that nothing changed.

// File: rtl/dll_ctrl_pkg.sv
package dll_ctrl_pkg;

  localparam int unsigned DLY_W   = 6;
  localparam int unsigned DLY_MID = 1 << (DLY_W - 1);

  typedef logic [DLY_W-1:0] dly_word_t;

  typedef enum logic {
    DIR_DN = 1'b0,
    DIR_UP = 1'b1
  } dir_e;

  function automatic dly_word_t bin2gray(input dly_word_t b);
    return b ^ (b >> 1);
  endfunction

  function automatic dly_word_t gray2bin(input dly_word_t g);
    dly_word_t b;
    b[DLY_W-1] = g[DLY_W-1];
    for (int i = DLY_W - 2; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/dll_rst_sync.sv
module dll_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/dll_upd_tick.sv
module dll_upd_tick #(
  parameter int unsigned UPD_DIV = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  generate
    if (UPD_DIV > 1) begin : g_div
      localparam int unsigned CW = $clog2(UPD_DIV);
      localparam logic [CW-1:0] LAST = CW'(UPD_DIV - 1);

      logic [CW-1:0] cnt_q;
      logic [CW-1:0] cnt_d;
      logic          cnt_en;

      assign cnt_en = 1'b1;
      assign tick   = (cnt_q == LAST);

      always_comb begin
        cnt_d = cnt_q;
        if (cnt_en) begin
          if (cnt_q == LAST) cnt_d = '0;
          else               cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
      end

      // R2: an update is never followed directly by another when UPD_DIV > 1
      a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end else begin : g_nodiv
      assign tick = 1'b1;
    end
  endgenerate

endmodule

// File: rtl/dll_gray_updn.sv
module dll_gray_updn
  import dll_ctrl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  dir_e      dir,
  output dly_word_t gray_q,
  output dly_word_t bin
);

  localparam dly_word_t MAXV  = {DLY_W{1'b1}};
  localparam dly_word_t MINV  = '0;
  localparam dly_word_t RST_G = bin2gray(dly_word_t'(DLY_MID));

  dly_word_t bin_nxt;
  dly_word_t gray_d;
  logic      at_top;
  logic      at_bot;

  assign bin    = gray2bin(gray_q);
  assign at_top = (bin == MAXV);
  assign at_bot = (bin == MINV);

  always_comb begin
    bin_nxt = bin;
    if (tick) begin
      if (dir == DIR_UP && !at_top)      bin_nxt = bin + 1'b1;
      else if (dir == DIR_DN && !at_bot) bin_nxt = bin - 1'b1;
    end
    gray_d = bin2gray(bin_nxt);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gray_q <= RST_G;
    else if (tick) gray_q <= gray_d;
  end

  // R5: at most one bit of the Gray word toggles per clock
  a_r5_single_bit_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(gray_q ^ $past(gray_q)) <= 1));

  // R2: no movement without an update tick
  a_r2_hold_between_ticks: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(gray_q));

  // R4: no wrap past the top
  a_r4_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dir == DIR_UP && at_top) |=> $stable(gray_q));

  // R4: no wrap past the bottom
  a_r4_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dir == DIR_DN && at_bot) |=> $stable(gray_q));

  // R3: an up-step never lowers the binary setting
  a_r3_up_not_down: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && dir == DIR_UP) |=> (bin >= $past(bin)));

endmodule

// File: rtl/dll_lock_det.sv
module dll_lock_det
  import dll_ctrl_pkg::*;
#(
  parameter int unsigned LOCK_ALT   = 4,
  parameter int unsigned UNLOCK_RUN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  dir_e dir,
  output logic locked
);

  localparam int unsigned AW = $clog2(LOCK_ALT + 1);
  localparam int unsigned RW = $clog2(UNLOCK_RUN + 2);
  localparam logic [AW-1:0] ALT_TGT = AW'(LOCK_ALT);
  localparam logic [RW-1:0] RUN_LIM = RW'(UNLOCK_RUN);
  localparam logic [RW-1:0] RUN_TOP = RW'(UNLOCK_RUN + 1);

  logic [AW-1:0] alt_q, alt_d;
  logic [RW-1:0] run_q, run_d;
  dir_e          prev_q, prev_d;
  logic          seen_q, seen_d;
  logic          lock_q, lock_d;

  always_comb begin
    alt_d  = alt_q;
    run_d  = run_q;
    prev_d = prev_q;
    seen_d = seen_q;
    lock_d = lock_q;
    if (tick) begin
      prev_d = dir;
      seen_d = 1'b1;
      if (!seen_q) begin
        alt_d = '0;
        run_d = RW'(1);
      end else if (dir != prev_q) begin
        alt_d = (alt_q == ALT_TGT) ? alt_q : alt_q + 1'b1;
        run_d = RW'(1);
      end else begin
        alt_d = '0;
        run_d = (run_q == RUN_TOP) ? run_q : run_q + 1'b1;
      end
      if (alt_d >= ALT_TGT)      lock_d = 1'b1;
      else if (run_d > RUN_LIM)  lock_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alt_q  <= '0;
      run_q  <= '0;
      prev_q <= DIR_DN;
      seen_q <= 1'b0;
      lock_q <= 1'b0;
    end else if (tick) begin
      alt_q  <= alt_d;
      run_q  <= run_d;
      prev_q <= prev_d;
      seen_q <= seen_d;
      lock_q <= lock_d;
    end
  end

  assign locked = lock_q;

  // R9: lock status only moves on update edges
  a_r9_lock_on_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(locked));

  // R7: lock can only rise on an alternating update
  a_r7_rise_needs_alternation: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_q && dir == prev_q) |=> !$rose(locked));

  // R8: lock can only fall on a repeated-direction update
  a_r8_fall_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && seen_q && dir != prev_q) |=> !$fell(locked));

endmodule

// File: rtl/dll_delay_ctrl.sv
module dll_delay_ctrl
  import dll_ctrl_pkg::*;
#(
  parameter int unsigned UPD_DIV    = 4,
  parameter int unsigned LOCK_ALT   = 4,
  parameter int unsigned UNLOCK_RUN = 3
) (
  input  logic               clk_ref,
  input  logic               rst_n,
  input  logic               phase_up,
  output logic [DLY_W-1:0]   dly_gray,
  output logic [DLY_W-1:0]   dly_bin,
  output logic               dll_locked
);

  logic      rst_int_n;
  logic      upd_tick;
  dir_e      dir;
  dly_word_t gray_w;
  dly_word_t bin_w;

  assign dir = phase_up ? DIR_UP : DIR_DN;

  dll_rst_sync #(
    .STAGES (2)
  ) u_rst_sync (
    .clk        (clk_ref),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  dll_upd_tick #(
    .UPD_DIV (UPD_DIV)
  ) u_tick (
    .clk   (clk_ref),
    .rst_n (rst_int_n),
    .tick  (upd_tick)
  );

  dll_gray_updn u_cnt (
    .clk    (clk_ref),
    .rst_n  (rst_int_n),
    .tick   (upd_tick),
    .dir    (dir),
    .gray_q (gray_w),
    .bin    (bin_w)
  );

  dll_lock_det #(
    .LOCK_ALT   (LOCK_ALT),
    .UNLOCK_RUN (UNLOCK_RUN)
  ) u_lock (
    .clk    (clk_ref),
    .rst_n  (rst_int_n),
    .tick   (upd_tick),
    .dir    (dir),
    .locked (dll_locked)
  );

  assign dly_gray = gray_w;
  assign dly_bin  = bin_w;

  // R6: binary copy agrees with the Gray word in its top bit
  a_r6_msb_agree: assert property (@(posedge clk_ref) disable iff (!rst_int_n)
    dly_bin[DLY_W-1] == dly_gray[DLY_W-1]);

endmodule

// File: tb/dll_delay_ctrl_tb.sv
module dll_delay_ctrl_tb;

  localparam int CLK_PERIOD = 10;
  localparam int UPD_DIV    = 4;
  localparam int LOCK_ALT   = 4;
  localparam int UNLOCK_RUN = 3;
  localparam int NVEC       = 10;

  // {direction, expected lock, expected binary setting}
  localparam logic [7:0] VEC [NVEC] = '{
    {1'b1, 1'b0, 6'd33},
    {1'b0, 1'b0, 6'd32},
    {1'b1, 1'b0, 6'd33},
    {1'b0, 1'b0, 6'd32},
    {1'b1, 1'b1, 6'd33},
    {1'b0, 1'b1, 6'd32},
    {1'b0, 1'b1, 6'd31},
    {1'b0, 1'b1, 6'd30},
    {1'b0, 1'b0, 6'd29},
    {1'b1, 1'b0, 6'd30}
  };

  logic       clk_ref;
  logic       rst_n;
  logic       phase_up;
  logic [5:0] dly_gray;
  logic [5:0] dly_bin;
  logic       dll_locked;

  int n_chk;
  int n_fail;
  bit done;

  dll_delay_ctrl #(
    .UPD_DIV    (UPD_DIV),
    .LOCK_ALT   (LOCK_ALT),
    .UNLOCK_RUN (UNLOCK_RUN)
  ) u_dut (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .phase_up   (phase_up),
    .dly_gray   (dly_gray),
    .dly_bin    (dly_bin),
    .dll_locked (dll_locked)
  );

  initial clk_ref = 1'b0;
  always #(CLK_PERIOD / 2) clk_ref = ~clk_ref;

  function automatic logic [5:0] to_gray(input logic [5:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_state(input string req, input logic [5:0] eb, input logic el);
    chk({req, " gray"}, int'(dly_gray), int'(to_gray(eb)));
    chk({req, " bin"},  int'(dly_bin),  int'(eb));
    chk({req, " lock"}, int'(dll_locked), int'(el));
  endtask

  // called on the falling edge just before an update edge
  task automatic do_update(input string req, input logic dir,
                           input logic [5:0] eb, input logic el);
    logic [5:0] g0;
    logic       l0;
    logic [5:0] gprev;
    gprev = dly_gray;
    phase_up = dir;
    @(posedge clk_ref);
    @(negedge clk_ref);
    chk_state(req, eb, el);
    chk("R5 one bit toggled", $countones(dly_gray ^ gprev) <= 1 ? 1 : 0, 1);
    g0 = dly_gray;
    l0 = dll_locked;
    for (int k = 0; k < UPD_DIV - 1; k++) begin
      phase_up = ~phase_up;
      @(negedge clk_ref);
      chk("R2 gray held between updates", int'(dly_gray), int'(g0));
      chk("R9 lock held between updates", int'(dll_locked), int'(l0));
    end
  endtask

  task automatic release_reset();
    rst_n = 1'b1;
    repeat (UPD_DIV + 1) @(posedge clk_ref);
    @(negedge clk_ref);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_ref);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [5:0] eb;
    n_chk    = 0;
    n_fail   = 0;
    done     = 1'b0;
    rst_n    = 1'b0;
    phase_up = 1'b1;
    repeat (3) @(negedge clk_ref);
    // R1: reset state
    chk_state("R1 reset value", 6'd32, 1'b0);
    chk("R1 reset gray code", int'(dly_gray), 48);

    release_reset();
    // R2: nothing moved before the first update edge
    chk_state("R2 before first update", 6'd32, 1'b0);

    // table walk: R3 stepping, R7 lock on alternation, R8 unlock on run
    for (int v = 0; v < NVEC; v++) begin
      do_update("R3 R7 R8 table", VEC[v][7], VEC[v][5:0], VEC[v][6]);
    end

    // R4: saturate at the top
    eb = 6'd30;
    for (int k = 0; k < 40; k++) begin
      eb = (eb == 6'd63) ? eb : eb + 6'd1;
      do_update("R4 climb to top", 1'b1, eb, 1'b0);
    end
    chk("R4 top value", int'(dly_bin), 63);
    chk("R5 top gray", int'(dly_gray), 32);
    chk("R6 top binary copy", int'(dly_bin), 63);

    // R4: saturate at the bottom
    for (int k = 0; k < 70; k++) begin
      eb = (eb == 6'd0) ? eb : eb - 6'd1;
      do_update("R4 fall to bottom", 1'b0, eb, 1'b0);
    end
    chk("R4 bottom value", int'(dly_bin), 0);
    chk("R5 bottom gray", int'(dly_gray), 0);

    // R1: reset in the middle of operation acts without a clock
    do_update("R3 step off bottom", 1'b1, 6'd1, 1'b0);
    #1 rst_n = 1'b0;
    #1;
    chk_state("R1 async reset", 6'd32, 1'b0);
    @(negedge clk_ref);
    release_reset();
    // R7: first update after reset is not an alternation
    do_update("R7 after reset 1", 1'b0, 6'd31, 1'b0);
    do_update("R7 after reset 2", 1'b1, 6'd32, 1'b0);
    do_update("R7 after reset 3", 1'b0, 6'd31, 1'b0);
    do_update("R7 after reset 4", 1'b1, 6'd32, 1'b0);
    do_update("R7 after reset 5", 1'b0, 6'd31, 1'b1);
    // R8: exactly UNLOCK_RUN repeats keep lock, one more drops it
    do_update("R8 run 2", 1'b0, 6'd30, 1'b1);
    do_update("R8 run 3", 1'b0, 6'd29, 1'b1);
    do_update("R8 run 4", 1'b0, 6'd28, 1'b0);
    // R6: binary copy matches decoded Gray
    chk("R6 binary copy", int'(dly_bin), 28);
    chk("R5 gray of 28", int'(dly_gray), int'(to_gray(6'd28)));

    finish_run();
  end

endmodule